// File: doc/BRIEF.md
# PWM Carrier Source Selector with External Clock Qualification

This block supplies the carrier that paces a class-D pulse-width modulator. By default the carrier comes from an internal oscillator, modelled as a programmable divider of a fast reference clock. A level flag asks for an external carrier instead, such as one shared by several amplifiers. While that flag is high the internal divider is stopped. The external clock is timed in reference cycles, and it becomes the carrier only after it has shown a valid frequency and a balanced duty cycle for several periods in a row.

The external clock, the select flag and the supply flag are synchronised into the reference domain. The measured period must fall inside a band that corresponds to roughly 210 to 600 kHz at a 125 MHz reference. The high time must lie strictly inside a narrow window around half the period, and this is checked by integer cross-multiplication. If the external clock stops, measures out of range, or is requested while the supply flag reports an inadequate supply, the block raises a fault and holds the carrier low. It never falls back to the internal oscillator on its own. The fault stays set until the select flag is released.

The controller has four states:
- `ST_INT_RUN`: the internal divider drives the carrier.
- `ST_QUALIFY`: the carrier is held low while external periods are counted.
- `ST_EXT_RUN`: the carrier follows the external clock.
- `ST_FAULT`: the carrier is gated low and the fault flag is set.

The transitions are:
- `ST_INT_RUN` moves to `ST_QUALIFY` on select, at a moment when the internal output is low.
- `ST_INT_RUN` moves to `ST_FAULT` on select with a bad supply.
- `ST_QUALIFY` moves to `ST_EXT_RUN` after enough good periods, once the external clock is low.
- `ST_QUALIFY` moves to `ST_FAULT` on a bad period, a stall, or a bad supply.
- `ST_QUALIFY` moves to `ST_INT_RUN` when select is released.
- `ST_EXT_RUN` moves to `ST_FAULT` on a bad period, a stall, or a bad supply.
- `ST_EXT_RUN` moves to `ST_INT_RUN` when select is released and the external clock is low.
- `ST_FAULT` moves to `ST_INT_RUN` when select is released.

Top module: `carrier_source_sel`

## Requirements
- R1: After reset, carrier_out, src_is_ext and fault are all 0.
- R2: With ext_sel low, carrier_out is a square wave whose high phase and low phase each last int_half reference cycles.
- R3: With ext_sel high and supply_ok high, carrier_out stays 0 and src_is_ext stays 0 until ACCEPT_PERIODS (default 4) consecutive measured periods have passed every check. The first external rising edge only starts the measurement. After acceptance, src_is_ext is 1 and carrier_out has the same high time as ext_clk.
- R4: A measured period, in reference cycles, must satisfy PER_MIN <= P <= PER_MAX (defaults 209 and 595). A period outside this band causes a fault, and both limits themselves are accepted.
- R5: A measured high time H must satisfy 19*P < 40*H < 21*P. A high time at exactly 47.5% of the period causes a fault.
- R6: If no edge of ext_clk is seen for TIMEOUT (default 1024) reference cycles while qualifying or running externally, a fault is raised.
- R7: A low supply_ok while ext_sel is high causes a fault, both when selecting and while running externally.
- R8: While fault is 1, carrier_out and src_is_ext are 0. The fault persists, even if the external clock becomes valid again, until ext_sel falls; after that the internal carrier resumes and fault returns to 0.
- R9: Every source change happens while carrier_out is low, so no carrier high pulse is shorter than the high time of the source that produced it, except a pulse cut short by a fault.
- R10: Releasing ext_sel during external operation returns the carrier to the internal divider, with src_is_ext 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External carrier candidate (asynchronous) |
| ext_sel | input | 1 | Level flag requesting the external carrier |
| supply_ok | input | 1 | High when the supply is adequate for external operation |
| int_half | input | DIV_W | Internal carrier half period in reference cycles |
| carrier_out | output | 1 | Selected carrier for the modulator |
| src_is_ext | output | 1 | 1 while the external clock drives the carrier |
| fault | output | 1 | External clock or supply rejected; carrier gated low |

## Verification
The hardest cases to reach from the ports are those where the external clock sits exactly on a limit: a period of 209 or 595 cycles, and a duty cycle of exactly 19/40 against 19/40 plus one cycle. These edges separate acceptance from rejection by a single comparison. The bench generates the external clock from counts of the reference clock on its falling edge, so each period and high time arrives with an exact integer length, and the boundary cases are hit deterministically. Glitch freedom is checked by a monitor that records the shortest carrier high pulse across every switch between sources.

// File: rtl/csel_pkg.sv
package csel_pkg;
    typedef enum logic [1:0] {
        ST_INT_RUN = 2'd0,
        ST_QUALIFY = 2'd1,
        ST_EXT_RUN = 2'd2,
        ST_FAULT   = 2'd3
    } csel_state_t;
endpackage

// File: rtl/csel_sync.sv
module csel_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/csel_int_osc.sv
module csel_int_osc #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             osc
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (half == '0) ? '0 : half - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            osc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            osc <= 1'b0;
        end else if (cnt >= limit) begin
            cnt <= '0;
            osc <= ~osc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: while stopped the oscillator output is held low
    osc_stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> !osc);
endmodule

// File: rtl/csel_ext_meter.sv
module csel_ext_meter #(
    parameter int PER_MIN  = 209,
    parameter int PER_MAX  = 595,
    parameter int DUTY_DEN = 40,
    parameter int DUTY_LO  = 19,
    parameter int DUTY_HI  = 21,
    parameter int TIMEOUT  = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ext_s,
    output logic meas_valid,
    output logic meas_good,
    output logic stalled
);
    localparam int CNT_W  = $clog2(PER_MAX + 2) + 1;
    localparam int IDLE_W = $clog2(TIMEOUT + 1);
    localparam int PROD_W = CNT_W + $clog2(DUTY_DEN + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

    logic              ext_d;
    logic              rise, fall;
    logic              primed;
    logic [CNT_W-1:0]  per_cnt;
    logic [CNT_W-1:0]  hi_lat;
    logic [IDLE_W-1:0] idle_cnt;
    logic [PROD_W-1:0] hi_scaled, lo_bound, hi_bound;
    logic              per_ok, duty_ok;

    assign rise = ext_s & ~ext_d;
    assign fall = ~ext_s & ext_d;

    always_comb begin
        hi_scaled = PROD_W'(hi_lat)  * PROD_W'(DUTY_DEN);
        lo_bound  = PROD_W'(per_cnt) * PROD_W'(DUTY_LO);
        hi_bound  = PROD_W'(per_cnt) * PROD_W'(DUTY_HI);
        per_ok    = (per_cnt >= CNT_W'(PER_MIN)) && (per_cnt <= CNT_W'(PER_MAX));
        duty_ok   = (hi_scaled > lo_bound) && (hi_scaled < hi_bound);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_d      <= 1'b0;
            primed     <= 1'b0;
            per_cnt    <= '0;
            hi_lat     <= '0;
            meas_valid <= 1'b0;
            meas_good  <= 1'b0;
        end else begin
            ext_d      <= ext_s;
            meas_valid <= 1'b0;
            if (!en) begin
                primed    <= 1'b0;
                per_cnt   <= '0;
                hi_lat    <= '0;
                meas_good <= 1'b0;
            end else if (rise) begin
                primed     <= 1'b1;
                per_cnt    <= CNT_W'(1);
                meas_valid <= primed;
                meas_good  <= per_ok && duty_ok;
            end else begin
                if (per_cnt != CNT_SAT) per_cnt <= per_cnt + 1'b1;
                if (fall) hi_lat <= per_cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            stalled  <= 1'b0;
        end else if (!en || rise || fall) begin
            idle_cnt <= '0;
            stalled  <= 1'b0;
        end else begin
            if (idle_cnt < IDLE_W'(TIMEOUT)) idle_cnt <= idle_cnt + 1'b1;
            stalled <= (idle_cnt >= IDLE_W'(TIMEOUT - 1));
        end
    end

    // R6
    idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= IDLE_W'(TIMEOUT));

    // R3
    first_edge_primes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> $past(primed));
endmodule

// File: rtl/carrier_source_sel.sv
module carrier_source_sel
    import csel_pkg::*;
#(
    parameter int DIV_W          = 12,
    parameter int PER_MIN        = 209,
    parameter int PER_MAX        = 595,
    parameter int DUTY_DEN       = 40,
    parameter int DUTY_LO        = 19,
    parameter int DUTY_HI        = 21,
    parameter int ACCEPT_PERIODS = 4,
    parameter int TIMEOUT        = 1024,
    parameter int SYNC_STAGES    = 2
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             ext_clk,
    input  logic             ext_sel,
    input  logic             supply_ok,
    input  logic [DIV_W-1:0] int_half,
    output logic             carrier_out,
    output logic             src_is_ext,
    output logic             fault
);
    localparam int ACC_W = $clog2(ACCEPT_PERIODS + 1);

    csel_state_t      state, state_n;
    logic [2:0]       raw_in, sync_out;
    logic             ext_s, sel_s, sup_s;
    logic             int_osc;
    logic             meas_valid, meas_good, stalled;
    logic             meas_bad;
    logic [ACC_W-1:0] good_cnt;
    logic             accepted;

    assign raw_in = {ext_clk, ext_sel, supply_ok};

    csel_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    assign ext_s = sync_out[2];
    assign sel_s = sync_out[1];
    assign sup_s = sync_out[0];

    csel_int_osc #(.DIV_W(DIV_W)) u_int_osc (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .run   (state == ST_INT_RUN),
        .half  (int_half),
        .osc   (int_osc)
    );

    csel_ext_meter #(
        .PER_MIN  (PER_MIN),
        .PER_MAX  (PER_MAX),
        .DUTY_DEN (DUTY_DEN),
        .DUTY_LO  (DUTY_LO),
        .DUTY_HI  (DUTY_HI),
        .TIMEOUT  (TIMEOUT)
    ) u_meter (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .en         ((state == ST_QUALIFY) || (state == ST_EXT_RUN)),
        .ext_s      (ext_s),
        .meas_valid (meas_valid),
        .meas_good  (meas_good),
        .stalled    (stalled)
    );

    assign meas_bad = stalled || (meas_valid && !meas_good);
    assign accepted = (good_cnt >= ACC_W'(ACCEPT_PERIODS));

    // consecutive good periods while qualifying
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            good_cnt <= '0;
        end else if (state != ST_QUALIFY) begin
            good_cnt <= '0;
        end else if (meas_valid && meas_good && !accepted) begin
            good_cnt <= good_cnt + 1'b1;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_INT_RUN: begin
                if (sel_s && !sup_s)             state_n = ST_FAULT;
                else if (sel_s && !int_osc)      state_n = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (!sel_s)                      state_n = ST_INT_RUN;
                else if (!sup_s || meas_bad)     state_n = ST_FAULT;
                else if (accepted && !ext_s)     state_n = ST_EXT_RUN;
            end
            ST_EXT_RUN: begin
                if (!sup_s || meas_bad)          state_n = ST_FAULT;
                else if (!sel_s && !ext_s)       state_n = ST_INT_RUN;
            end
            ST_FAULT: begin
                if (!sel_s)                      state_n = ST_INT_RUN;
            end
            default:                             state_n = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state <= ST_INT_RUN;
        else        state <= state_n;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            carrier_out <= 1'b0;
            src_is_ext  <= 1'b0;
            fault       <= 1'b0;
        end else begin
            unique case (state_n)
                ST_INT_RUN: carrier_out <= int_osc;
                ST_EXT_RUN: carrier_out <= ext_s;
                default:    carrier_out <= 1'b0;
            endcase
            src_is_ext <= (state_n == ST_EXT_RUN);
            fault      <= (state_n == ST_FAULT);
        end
    end

    // R8
    fault_gates_carrier_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        fault |-> (!carrier_out && !src_is_ext));

    // R7
    ext_needs_supply_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        src_is_ext |-> $past(sup_s));

    // R3
    ext_entry_needs_sel_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(src_is_ext) |-> $past(sel_s) && !carrier_out);

    // R9
    switch_when_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (src_is_ext != $past(src_is_ext)) && !fault |-> !carrier_out);

    // R8
    fault_holds_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(fault) && $past(sel_s) |-> fault);
endmodule

// File: tb/test_carrier_source_sel.sv
module test_carrier_source_sel;
    localparam int HALF_INT = 179;
    localparam int TMO      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0;
    logic        ext_sel = 1'b0;
    logic        supply_ok = 1'b1;
    logic [11:0] int_half = 12'(HALF_INT);
    logic        carrier_out, src_is_ext, fault;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  ext_run  = 1'b0;
    int  ext_per  = 300;
    int  ext_hi   = 150;
    int  min_run  = 100000;
    int  run_len  = 0;

    always #4 clk = ~clk;

    carrier_source_sel i_carrier_source_sel (
        .clk_ref     (clk),
        .rst_n       (rst_n),
        .ext_clk     (ext_clk),
        .ext_sel     (ext_sel),
        .supply_ok   (supply_ok),
        .int_half    (int_half),
        .carrier_out (carrier_out),
        .src_is_ext  (src_is_ext),
        .fault       (fault)
    );

    // external clock source, exact integer counts on the falling edge
    initial begin
        forever begin
            if (ext_run) begin
                ext_clk = 1'b1;
                repeat (ext_hi) @(negedge clk);
                ext_clk = 1'b0;
                repeat (ext_per - ext_hi) @(negedge clk);
            end else begin
                ext_clk = 1'b0;
                @(negedge clk);
            end
        end
    end

    // shortest high pulse that did not end in reset or fault (R9)
    initial begin
        forever begin
            @(negedge clk);
            if (carrier_out) begin
                run_len++;
            end else begin
                if (run_len > 0 && rst_n && !fault && run_len < min_run) min_run = run_len;
                run_len = 0;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_high(output int len);
        int guard = 0;
        len = 0;
        while (carrier_out && guard < 5000) begin @(negedge clk); guard++; end
        while (!carrier_out && guard < 5000) begin @(negedge clk); guard++; end
        while (carrier_out && guard < 5000) begin len++; @(negedge clk); guard++; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ext_run = 1'b0;
        ext_sel = 1'b0;
        supply_ok = 1'b1;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic t_reset();
        do_reset();
        check(!carrier_out && !src_is_ext && !fault, "R1 reset outputs",
              {carrier_out, src_is_ext, fault}, 0);
    endtask

    task automatic t_internal();
        int len;
        do_reset();
        measure_high(len);
        check(len == HALF_INT, "R2 internal high phase", len, HALF_INT);
        check(!src_is_ext && !fault, "R2 internal source flags", {src_is_ext, fault}, 0);
    endtask

    task automatic t_ext_good(input int per, input int hi, input string req);
        int len;
        do_reset();
        ext_per = per; ext_hi = hi; ext_run = 1'b1;
        ext_sel = 1'b1;
        wait_cyc(3 * per);
        check(!src_is_ext && !fault, {req, " still qualifying"}, {src_is_ext, fault}, 0);
        wait_cyc(8 * per);
        check(src_is_ext && !fault, {req, " accepted"}, {src_is_ext, fault}, 2);
        measure_high(len);
        check(len == hi, {req, " carrier follows external"}, len, hi);
    endtask

    task automatic t_ext_bad(input int per, input int hi, input string req);
        do_reset();
        ext_per = per; ext_hi = hi; ext_run = 1'b1;
        ext_sel = 1'b1;
        wait_cyc(11 * per);
        check(fault && !src_is_ext && !carrier_out, {req, " rejected"},
              {fault, src_is_ext, carrier_out}, 4);
    endtask

    task automatic t_stall();
        t_ext_good(300, 150, "R6 setup");
        ext_run = 1'b0;
        wait_cyc(TMO + 100);
        check(fault && !carrier_out, "R6 stalled clock faults", {fault, carrier_out}, 2);
    endtask

    task automatic t_supply();
        do_reset();
        supply_ok = 1'b0;
        ext_per = 300; ext_hi = 150; ext_run = 1'b1;
        ext_sel = 1'b1;
        wait_cyc(10);
        check(fault && !carrier_out, "R7 select with low supply", {fault, carrier_out}, 2);
        t_ext_good(300, 150, "R7 setup");
        supply_ok = 1'b0;
        wait_cyc(10);
        check(fault && !src_is_ext, "R7 supply drop in external", {fault, src_is_ext}, 2);
    endtask

    task automatic t_latch();
        int len;
        do_reset();
        ext_per = 300; ext_hi = 142; ext_run = 1'b1;
        ext_sel = 1'b1;
        wait_cyc(3000);
        ext_hi = 150;
        wait_cyc(3000);
        check(fault && !src_is_ext, "R8 fault persists with valid clock", {fault, src_is_ext}, 2);
        ext_sel = 1'b0;
        wait_cyc(20);
        check(!fault && !src_is_ext, "R8 release clears fault", {fault, src_is_ext}, 0);
        measure_high(len);
        check(len == HALF_INT, "R8 internal resumes", len, HALF_INT);
    endtask

    task automatic t_return();
        int len;
        t_ext_good(300, 150, "R10 setup");
        ext_sel = 1'b0;
        wait_cyc(400);
        check(!src_is_ext && !fault, "R10 back to internal", {src_is_ext, fault}, 0);
        measure_high(len);
        check(len == HALF_INT, "R10 internal high phase", len, HALF_INT);
    endtask

    initial begin
        t_reset();
        t_internal();
        t_ext_good(300, 150, "R3 nominal");
        t_ext_good(209, 105, "R4 shortest period");
        t_ext_good(595, 298, "R4 longest period");
        t_ext_good(400, 191, "R5 just inside duty");
        t_ext_bad(208, 104, "R4 period too short");
        t_ext_bad(596, 298, "R4 period too long");
        t_ext_bad(400, 190, "R5 duty exactly low limit");
        t_ext_bad(300, 142, "R5 duty low");
        t_ext_bad(300, 158, "R5 duty high");
        t_stall();
        t_supply();
        t_latch();
        t_return();
        check(min_run >= 105, "R9 shortest carrier pulse", min_run, 105);
        summary();
        $finish;
    end
endmodule